// File: doc/BRIEF.md
# Clock Driver Output Divider Stage

This block turns one source clock into a family of related clock outputs for board-level clock distribution. The source is either the oscillator of an external phase-locked loop or, with the loop bypassed, one of two reference inputs that then act as a test clock. A single down-counter clocked by that source produces a double-rate clock, five identical base-rate clocks, one inverted base-rate clock and a half-rate clock. Because every tap comes from one counter, all rising edges line up.

A frequency-select input adds one extra divide-by-two stage when low. Bypassing the loop complements the polarity of every output. Both the divide setting and the polarity are sampled only at a counter wrap, so a change never produces a short pulse on an output.

One active-low input does two jobs. It clears the counter and drops the enable of every output, which models high impedance. While that input is low the source clock keeps sampling the mode inputs, so the outputs leave reset already in the requested mode.

Top module: `clkdrv_div_stage`

## Requirements
- R1: With the select input high, after release the counter advances once per source rising edge. After edge e, the double-rate output is high when e mod 2 = 1. Each base output is high when e mod 4 is 1 or 2. The half-rate output is high when e mod 8 is 1 to 4. In normal mode the polarity is not inverted.
- R2: Every rising edge of the half-rate output falls on a rising edge of the base outputs. Every rising edge of the base outputs falls on a rising edge of the double-rate output.
- R3: All five base outputs carry the same value. The inverted output is always the complement of a base output.
- R4: With the select input low, the periods double. The double-rate output is high when e mod 4 is 1 or 2. The base outputs are high when e mod 8 is 1 to 4. The half-rate output is high when e mod 16 is 1 to 8.
- R5: With the loop-enable input low, the counter is clocked by the selected reference input and not by the oscillator input.
- R6: The reference-select input picks the second reference when high and the first reference when low. Edges on the reference that is not selected do not move the outputs.
- R7: With the loop-enable input low, every output is the complement of its normal-mode value for the same counter state.
- R8: While the enable/reset input is low, all eight output enables are low at once, without waiting for a clock. The counter is held at zero, so every tap is low before polarity is applied. The first source edge after release raises all three taps together.
- R9: A change on the select or loop-enable input takes effect only at a counter wrap. A wrap is the edge that leaves the all-zero state of the active taps. Until then the outputs keep their old period and polarity.
- R10: While held in reset, every source edge loads the select and loop-enable inputs. The first cycle after release therefore already uses the requested mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| osc_clk_i | input | 1 | Oscillator clock from the external loop |
| sync_a_i | input | 1 | First reference input, bypass clock when reference-select is low |
| sync_b_i | input | 1 | Second reference input, bypass clock when reference-select is high |
| ref_sel_i | input | 1 | Reference select, 1 picks sync_b_i |
| pll_on_i | input | 1 | 1 uses oscillator, 0 bypasses to the selected reference and inverts outputs |
| fsel_i | input | 1 | 1 divide-by-one, 0 adds an extra divide-by-two |
| oe_rst_n_i | input | 1 | Active-low output enable and counter reset |
| dbl_o | output | 1 | Double-rate clock value |
| dbl_en_o | output | 1 | Drive enable for dbl_o |
| base_o | output | N_BASE | In-phase base-rate clock values |
| base_en_o | output | N_BASE | Drive enables for base_o |
| inv_o | output | 1 | Inverted base-rate clock value |
| inv_en_o | output | 1 | Drive enable for inv_o |
| half_o | output | 1 | Half-rate clock value |
| half_en_o | output | 1 | Drive enable for half_o |

## Verification
A wrong counter value shows up on the double-rate output within one or two source edges, because that tap follows the counter's lowest active bit on every edge. A wrong mode register shows up no later than the following wrap, at most sixteen source edges later, as a wrong period or an inverted level on all outputs together. A source mux that picks the wrong clock shows up as outputs that freeze or advance against a gated reference within a few edges. The bench keeps its own edge count and wrap model and compares every output and enable at each falling edge.

// File: rtl/clkdrv_pkg.sv
package clkdrv_pkg;

  // Tap order inside the divider: 0 double-rate, 1 base-rate, 2 half-rate
  localparam int unsigned TAPS    = 3;
  localparam int unsigned TAP_DBL = 0;
  localparam int unsigned TAP_BAS = 1;
  localparam int unsigned TAP_HLF = 2;

  typedef struct packed {
    logic div2;  // extra divide-by-two active
    logic inv;   // bypass polarity inversion active
  } mode_t;

  // Mode requested by the pins, in the form the divider stores it
  function automatic mode_t mode_from_pins(input logic fsel, input logic pll_on);
    mode_t m;
    m.div2 = ~fsel;
    m.inv  = ~pll_on;
    return m;
  endfunction

  // A tap is the counter bit offset by the prescale depth when div2 is set
  function automatic int unsigned tap_lsb(input logic div2, input int unsigned pre);
    return div2 ? pre : 0;
  endfunction

endpackage

// File: rtl/clkdrv_src_sel.sv
module clkdrv_src_sel (
  input  logic osc_clk_i,
  input  logic sync_a_i,
  input  logic sync_b_i,
  input  logic ref_sel_i,
  input  logic pll_on_i,
  output logic src_clk_o
);

  logic ref_clk;

  always_comb begin
    ref_clk   = ref_sel_i ? sync_b_i : sync_a_i;
    src_clk_o = pll_on_i ? osc_clk_i : ref_clk;
  end

endmodule

// File: rtl/clkdrv_div_core.sv
module clkdrv_div_core
  import clkdrv_pkg::*;
#(
  parameter int unsigned PRE = 1
) (
  input  logic            src_clk_i,
  input  logic            rst_n_i,
  input  logic            fsel_i,
  input  logic            pll_on_i,
  output logic [TAPS-1:0] taps_o,
  output logic            inv_o
);

  localparam int unsigned CW = TAPS + PRE;

  logic [CW-1:0] cnt_q;
  mode_t         mode_q;
  logic          wrap;
  logic          run_q;

  // Wrap: the active taps sit at all-zero, next edge reloads all ones
  always_comb begin
    if (mode_q.div2) wrap = (cnt_q == '0);
    else             wrap = (cnt_q[TAPS-1:0] == '0);
  end

  always_ff @(posedge src_clk_i or negedge rst_n_i) begin
    if (!rst_n_i)  cnt_q <= '0;
    else if (wrap) cnt_q <= '1;
    else           cnt_q <= cnt_q - CW'(1);
  end

  // Mode is loaded during reset and at each wrap only
  always_ff @(posedge src_clk_i) begin
    if (!rst_n_i || wrap) mode_q <= mode_from_pins(fsel_i, pll_on_i);
  end

  always_comb begin
    if (mode_q.div2) taps_o = cnt_q[CW-1 -: TAPS];
    else             taps_o = cnt_q[TAPS-1:0];
    inv_o = mode_q.inv;
  end

  always_ff @(posedge src_clk_i or negedge rst_n_i) begin
    if (!rst_n_i) run_q <= 1'b0;
    else          run_q <= 1'b1;
  end

  // R9: mode bits move only after a wrap edge
  a_r9_mode_hold: assert property (@(posedge src_clk_i) disable iff (!rst_n_i)
    (run_q && !$past(wrap)) |-> $stable(mode_q.div2));

  a_r9_pol_hold: assert property (@(posedge src_clk_i) disable iff (!rst_n_i)
    (run_q && !$past(wrap)) |-> $stable(mode_q.inv));

  // R1: outside a wrap the counter steps down by one
  a_r1_count_step: assert property (@(posedge src_clk_i) disable iff (!rst_n_i)
    (run_q && !$past(wrap)) |-> (cnt_q == $past(cnt_q) - CW'(1)));

  // R2: a slower tap never rises without the next faster tap
  for (genvar g = 0; g < TAPS - 1; g++) begin : g_align
    a_r2_rise_aligned: assert property (@(posedge src_clk_i) disable iff (!rst_n_i)
      (run_q && $rose(taps_o[g+1])) |-> $rose(taps_o[g]));
  end

endmodule

// File: rtl/clkdrv_out_stage.sv
module clkdrv_out_stage
  import clkdrv_pkg::*;
#(
  parameter int unsigned N_BASE = 5
) (
  input  logic [TAPS-1:0]   taps_i,
  input  logic              inv_i,
  input  logic              oe_i,
  output logic              dbl_o,
  output logic              dbl_en_o,
  output logic [N_BASE-1:0] base_o,
  output logic [N_BASE-1:0] base_en_o,
  output logic              inv_o,
  output logic              inv_en_o,
  output logic              half_o,
  output logic              half_en_o
);

  logic base_lvl;

  always_comb begin
    base_lvl  = taps_i[TAP_BAS] ^ inv_i;
    dbl_o     = taps_i[TAP_DBL] ^ inv_i;
    half_o    = taps_i[TAP_HLF] ^ inv_i;
    inv_o     = ~base_lvl;
    dbl_en_o  = oe_i;
    inv_en_o  = oe_i;
    half_en_o = oe_i;
  end

  for (genvar g = 0; g < N_BASE; g++) begin : g_base
    assign base_o[g]    = base_lvl;
    assign base_en_o[g] = oe_i;
  end

endmodule

// File: rtl/clkdrv_div_stage.sv
module clkdrv_div_stage
  import clkdrv_pkg::*;
#(
  parameter int unsigned N_BASE          = 5,
  parameter int unsigned PRESCALE_STAGES = 1
) (
  input  logic              osc_clk_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  input  logic              ref_sel_i,
  input  logic              pll_on_i,
  input  logic              fsel_i,
  input  logic              oe_rst_n_i,
  output logic              dbl_o,
  output logic              dbl_en_o,
  output logic [N_BASE-1:0] base_o,
  output logic [N_BASE-1:0] base_en_o,
  output logic              inv_o,
  output logic              inv_en_o,
  output logic              half_o,
  output logic              half_en_o
);

  logic            src_clk;
  logic [TAPS-1:0] taps;
  logic            pol_inv;

  clkdrv_src_sel u_src (
    .osc_clk_i (osc_clk_i),
    .sync_a_i  (sync_a_i),
    .sync_b_i  (sync_b_i),
    .ref_sel_i (ref_sel_i),
    .pll_on_i  (pll_on_i),
    .src_clk_o (src_clk)
  );

  clkdrv_div_core #(.PRE(PRESCALE_STAGES)) u_div (
    .src_clk_i (src_clk),
    .rst_n_i   (oe_rst_n_i),
    .fsel_i    (fsel_i),
    .pll_on_i  (pll_on_i),
    .taps_o    (taps),
    .inv_o     (pol_inv)
  );

  clkdrv_out_stage #(.N_BASE(N_BASE)) u_out (
    .taps_i    (taps),
    .inv_i     (pol_inv),
    .oe_i      (oe_rst_n_i),
    .dbl_o     (dbl_o),
    .dbl_en_o  (dbl_en_o),
    .base_o    (base_o),
    .base_en_o (base_en_o),
    .inv_o     (inv_o),
    .inv_en_o  (inv_en_o),
    .half_o    (half_o),
    .half_en_o (half_en_o)
  );

endmodule

// File: tb/clkdrv_div_stage_tb.sv
module clkdrv_div_stage_tb_top;

  localparam int NB = 5;

  logic osc_clk = 1'b0;
  logic gate_a = 1'b1, gate_b = 1'b1;
  logic ref_sel = 1'b0, pll_on = 1'b1, fsel = 1'b1, oe_n = 1'b0;
  logic sync_a, sync_b;
  logic dbl, dbl_en, inv, inv_en, half, half_en;
  logic [NB-1:0] base, base_en;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  // model state
  int   m_e   = 0;
  logic m_div = 1'b0;
  logic m_pol = 1'b0;

  always #4 osc_clk = ~osc_clk;
  assign sync_a = osc_clk & gate_a;
  assign sync_b = osc_clk & gate_b;

  clkdrv_div_stage #(.N_BASE(NB)) dut_i (
    .osc_clk_i (osc_clk), .sync_a_i (sync_a), .sync_b_i (sync_b),
    .ref_sel_i (ref_sel), .pll_on_i (pll_on), .fsel_i (fsel),
    .oe_rst_n_i (oe_n),
    .dbl_o (dbl), .dbl_en_o (dbl_en), .base_o (base), .base_en_o (base_en),
    .inv_o (inv), .inv_en_o (inv_en), .half_o (half), .half_en_o (half_en)
  );

  // Reference model: edges since the last wrap and the latched mode
  always @(posedge osc_clk) begin
    bit act;
    int len;
    act = pll_on || (ref_sel ? gate_b : gate_a);
    if (!oe_n) begin
      m_e = 0;
      if (act) begin m_div = ~fsel; m_pol = ~pll_on; end
    end else if (act) begin
      len = m_div ? 16 : 8;
      if (m_e == 0 || m_e == len) begin
        m_div = ~fsel; m_pol = ~pll_on; m_e = 1;
      end else begin
        m_e = m_e + 1;
      end
    end
  end

  function automatic logic hi_phase(input int e, input int p);
    int r;
    r = e % p;
    return (r >= 1) && (r <= p / 2);
  endfunction

  task automatic chk(input string req);
    logic [2*NB+5:0] act, exp;
    logic b, e_en;
    int k;
    k    = m_div ? 2 : 1;
    b    = hi_phase(m_e, 4 * k) ^ m_pol;
    e_en = oe_n;
    act  = {dbl, dbl_en, base, base_en, inv, inv_en, half, half_en};
    exp  = {hi_phase(m_e, 2 * k) ^ m_pol, e_en, {NB{b}}, {NB{e_en}},
            ~b, e_en, hi_phase(m_e, 8 * k) ^ m_pol, e_en};
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b (e=%0d)", req, act, exp, m_e);
    end
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge osc_clk);
      chk(req);
    end
  endtask

  task automatic hold_reset(input string req);
    @(negedge osc_clk);
    oe_n = 1'b0;
    run(3, req);
  endtask

  task automatic t_reset;
    hold_reset("R8 R10");
  endtask

  task automatic t_div1;
    oe_n = 1'b1;
    run(24, "R1 R2 R3");
  endtask

  task automatic t_div2;
    fsel = 1'b0;
    hold_reset("R10");
    oe_n = 1'b1;
    run(40, "R4 R2");
  endtask

  task automatic t_bypass;
    fsel = 1'b1; pll_on = 1'b0; ref_sel = 1'b0; gate_a = 1'b1; gate_b = 1'b0;
    hold_reset("R7 R10");
    oe_n = 1'b1;
    run(20, "R5 R7");
  endtask

  task automatic t_refsel;
    ref_sel = 1'b1; gate_b = 1'b1; gate_a = 1'b0;
    hold_reset("R6");
    oe_n = 1'b1;
    run(6, "R6");
    gate_b = 1'b0; gate_a = 1'b1;
    run(6, "R6");
    gate_b = 1'b1;
    run(10, "R6 R5");
  endtask

  task automatic t_change;
    pll_on = 1'b1; fsel = 1'b1; ref_sel = 1'b0; gate_a = 1'b1; gate_b = 1'b1;
    hold_reset("R8");
    oe_n = 1'b1;
    run(10, "R1");
    fsel = 1'b0;
    run(30, "R9");
    pll_on = 1'b0;
    run(40, "R9 R7");
    fsel = 1'b1;
    run(20, "R9");
  endtask

  task automatic t_oe_mid;
    pll_on = 1'b1; fsel = 1'b1;
    run(13, "R1");
    oe_n = 1'b0;
    #1;
    checks++;
    if ({dbl_en, base_en, inv_en, half_en} !== '0) begin
      failures++;
      $display("FAIL R8 actual=%b expected=%b", {dbl_en, base_en, inv_en, half_en},
               {(NB+3){1'b0}});
    end
    run(3, "R8");
    oe_n = 1'b1;
    run(10, "R8 R1");
  endtask

  initial begin
    t_reset();
    t_div1();
    t_div2();
    t_bypass();
    t_refsel();
    t_change();
    t_oe_mid();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule